// File: doc/BRIEF.md
# Shuffle-Exchange Route Sequencer

This block walks a packet's path through a shuffle-exchange network of 2^K nodes, one link per clock. A node in such a network has two outgoing links. The shuffle link leads to the node whose address is the current one rotated left by one bit. The exchange link leads to the node whose address differs only in the least significant bit. The sequencer takes a source and a destination address on a start pulse. It then emits a stream of hops, each tagged with its link kind and the address of the node it reaches.

The route places the destination bits one at a time, most significant first. At each step the sequencer first fixes the low bit of the current address with an exchange when needed. It then rotates the address with a shuffle, except after the last step. The route stops as soon as the current address equals the destination. A route therefore never takes more than 2K-1 hops. A busy flag covers the whole route, and a hop counter reports the length of the last route.

Top module: `se_route_seq`

## Requirements
- R1: While reset is asserted and right after it is released, busy, hop_valid and done are low and hop_count is 0.
- R2: A start pulse seen while busy is low captures src_addr and dst_addr, and busy is high in the next cycle.
- R3: A shuffle hop shows hop_type = 0 and a next_addr equal to the current address rotated left by one bit (the old MSB becomes the new LSB).
- R4: An exchange hop shows hop_type = 1 and a next_addr equal to the current address with bit 0 inverted.
- R5: Steps run j = 0 to K-1. At step j, an exchange is issued only if the current bit 0 differs from destination bit K-1-j. A shuffle then follows if j < K-1. Every busy cycle before done carries exactly one hop, and the next hop starts from the address the previous hop reached.
- R6: done is high for exactly one cycle, the first busy cycle in which the current address equals the destination. No hop is valid in that cycle, and busy is low in the cycle after it.
- R7: When source equals destination, no hop is emitted and done is high in the first cycle after the start is captured.
- R8: For every source and destination pair, the last hop reaches the destination and the route has at most 2K-1 hops.
- R9: A start pulse while busy is high, including the done cycle, is ignored: the route in flight and its addresses are unchanged, and busy falls after done as usual.
- R10: hop_count clears when a start is captured, counts each emitted hop, and holds its value after the route ends until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a route with the given addresses |
| src_addr | input | ADDR_BITS | Source node address |
| dst_addr | input | ADDR_BITS | Destination node address |
| busy | output | 1 | A route is in progress |
| hop_valid | output | 1 | A hop is emitted this cycle |
| hop_type | output | 1 | 0 = shuffle, 1 = exchange |
| next_addr | output | ADDR_BITS | Node reached by this hop |
| done | output | 1 | The current address equals the destination |
| hop_count | output | $clog2(2*ADDR_BITS) | Hops emitted in the current or last route |

## Verification
The assertions assume that start is a level sampled on the clock and that src_addr and dst_addr are valid whenever start is high. They do not assume that start stays low during a route, because rejecting such pulses is part of the contract. The stimulus drives every input on the falling edge, holds the addresses steady across the capturing edge, and deliberately pulses start in mid-route and in the done cycle so that the ignore path is exercised. All 64 address pairs at the default width are routed back to back, each beginning only after busy has fallen.

// File: rtl/se_route_pkg.sv
package se_route_pkg;

  typedef enum logic {
    HOP_SHUF = 1'b0,
    HOP_EXCH = 1'b1
  } hop_kind_e;

  typedef enum logic {
    PH_FIX = 1'b0,
    PH_ROT = 1'b1
  } step_phase_e;

endpackage

// File: rtl/se_move_select.sv
module se_move_select
  import se_route_pkg::*;
#(
  parameter int ADDR_BITS = 3,
  parameter int STEP_W    = 2
) (
  input  logic [ADDR_BITS-1:0] cur_addr,
  input  logic [ADDR_BITS-1:0] tgt_addr,
  input  logic [STEP_W-1:0]    step,
  input  step_phase_e          phase,
  output logic                 at_dest,
  output logic                 move_valid,
  output hop_kind_e            move_kind,
  output logic [ADDR_BITS-1:0] move_addr,
  output logic                 step_inc,
  output step_phase_e          phase_nxt
);

  logic [ADDR_BITS-1:0] rot_addr;
  logic [ADDR_BITS-1:0] flip_addr;
  logic                 want_bit;

  // Address reached over each of the two links.
  assign rot_addr  = {cur_addr[ADDR_BITS-2:0], cur_addr[ADDR_BITS-1]};
  assign flip_addr = {cur_addr[ADDR_BITS-1:1], ~cur_addr[0]};

  // Destination bit that step j must place: bit ADDR_BITS-1-j.
  always_comb begin
    want_bit = 1'b0;
    for (int i = 0; i < ADDR_BITS; i++) begin
      if (step == STEP_W'(i)) begin
        want_bit = tgt_addr[ADDR_BITS-1-i];
      end
    end
  end

  always_comb begin
    at_dest    = (cur_addr == tgt_addr);
    move_valid = 1'b0;
    move_kind  = HOP_SHUF;
    move_addr  = cur_addr;
    step_inc   = 1'b0;
    phase_nxt  = phase;
    if (!at_dest) begin
      move_valid = 1'b1;
      if ((phase == PH_ROT) || (cur_addr[0] == want_bit)) begin
        move_kind = HOP_SHUF;
        move_addr = rot_addr;
        step_inc  = 1'b1;
        phase_nxt = PH_FIX;
      end else begin
        move_kind = HOP_EXCH;
        move_addr = flip_addr;
        phase_nxt = PH_ROT;
      end
    end
  end

endmodule

// File: rtl/se_hop_counter.sv
module se_hop_counter #(
  parameter int MAX_HOPS = 5,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_nxt;
  logic             count_en;

  assign count_en = clr | inc;

  always_comb begin
    if (clr) count_nxt = '0;
    else     count_nxt = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_nxt;
  end

  // R8: a route never asks for a hop beyond the bound
  a_r8_hop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> (count < CNT_W'(MAX_HOPS)));

endmodule

// File: rtl/se_route_fsm.sv
module se_route_fsm
  import se_route_pkg::*;
#(
  parameter int ADDR_BITS = 3,
  parameter int STEP_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_BITS-1:0] src_addr,
  input  logic [ADDR_BITS-1:0] dst_addr,
  input  logic                 at_dest,
  input  logic                 move_valid,
  input  hop_kind_e            move_kind,
  input  logic [ADDR_BITS-1:0] move_addr,
  input  logic                 step_inc,
  input  step_phase_e          phase_nxt,
  output logic                 busy,
  output logic [ADDR_BITS-1:0] cur_addr,
  output logic [ADDR_BITS-1:0] tgt_addr,
  output logic [STEP_W-1:0]    step,
  output step_phase_e          phase,
  output logic                 accept,
  output logic                 fin
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(ADDR_BITS-1);

  logic                 adv;
  logic                 busy_nxt;
  logic [ADDR_BITS-1:0] cur_nxt;
  logic [ADDR_BITS-1:0] tgt_nxt;
  logic [STEP_W-1:0]    step_nxt;
  step_phase_e          phase_reg_nxt;
  logic                 busy_en;
  logic                 walk_en;

  assign accept  = start & ~busy;
  assign fin     = busy & at_dest;
  assign adv     = busy & move_valid;
  assign busy_en = accept | fin;
  assign walk_en = accept | adv;

  always_comb begin
    busy_nxt      = accept;
    tgt_nxt       = dst_addr;
    cur_nxt       = src_addr;
    step_nxt      = '0;
    phase_reg_nxt = PH_FIX;
    if (!accept) begin
      tgt_nxt       = tgt_addr;
      cur_nxt       = move_addr;
      step_nxt      = step_inc ? (step + STEP_W'(1)) : step;
      phase_reg_nxt = phase_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy <= 1'b0;
    else if (busy_en) busy <= busy_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_addr <= '0;
    else if (accept) tgt_addr <= tgt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      step     <= '0;
      phase    <= PH_FIX;
    end else if (walk_en) begin
      cur_addr <= cur_nxt;
      step     <= step_nxt;
      phase    <= phase_reg_nxt;
    end
  end

  // R5: no rotation is requested once the last bit has been placed
  a_r5_no_rot_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && move_valid && (move_kind == HOP_SHUF)) |-> (step != LAST_STEP));

  // R9: the captured destination stays put while a route runs
  a_r9_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_dest) |=> $stable(tgt_addr));

  // R6: the route closes the cycle after the destination is reached
  a_r6_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && at_dest) |=> !busy);

  // R5: each move starts where the previous one ended
  a_r5_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && move_valid) |=> (cur_addr == $past(move_addr)));

endmodule

// File: rtl/se_route_seq.sv
module se_route_seq
  import se_route_pkg::*;
#(
  parameter int ADDR_BITS = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [ADDR_BITS-1:0]              src_addr,
  input  logic [ADDR_BITS-1:0]              dst_addr,
  output logic                              busy,
  output logic                              hop_valid,
  output logic                              hop_type,
  output logic [ADDR_BITS-1:0]              next_addr,
  output logic                              done,
  output logic [$clog2(2*ADDR_BITS)-1:0]    hop_count
);

  localparam int STEP_W   = (ADDR_BITS > 1) ? $clog2(ADDR_BITS) : 1;
  localparam int MAX_HOPS = 2 * ADDR_BITS - 1;
  localparam int CNT_W    = $clog2(2 * ADDR_BITS);

  logic [ADDR_BITS-1:0] cur_addr;
  logic [ADDR_BITS-1:0] tgt_addr;
  logic [STEP_W-1:0]    step;
  step_phase_e          phase;
  logic                 at_dest;
  logic                 move_valid;
  hop_kind_e            move_kind;
  logic [ADDR_BITS-1:0] move_addr;
  logic                 step_inc;
  step_phase_e          phase_nxt;
  logic                 accept;
  logic                 fin;

  se_move_select #(
    .ADDR_BITS (ADDR_BITS),
    .STEP_W    (STEP_W)
  ) u_select (
    .cur_addr   (cur_addr),
    .tgt_addr   (tgt_addr),
    .step       (step),
    .phase      (phase),
    .at_dest    (at_dest),
    .move_valid (move_valid),
    .move_kind  (move_kind),
    .move_addr  (move_addr),
    .step_inc   (step_inc),
    .phase_nxt  (phase_nxt)
  );

  se_route_fsm #(
    .ADDR_BITS (ADDR_BITS),
    .STEP_W    (STEP_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .at_dest    (at_dest),
    .move_valid (move_valid),
    .move_kind  (move_kind),
    .move_addr  (move_addr),
    .step_inc   (step_inc),
    .phase_nxt  (phase_nxt),
    .busy       (busy),
    .cur_addr   (cur_addr),
    .tgt_addr   (tgt_addr),
    .step       (step),
    .phase      (phase),
    .accept     (accept),
    .fin        (fin)
  );

  se_hop_counter #(
    .MAX_HOPS (MAX_HOPS),
    .CNT_W    (CNT_W)
  ) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (hop_valid),
    .count (hop_count)
  );

  assign hop_valid = busy & move_valid;
  assign hop_type  = move_kind;
  assign next_addr = move_addr;
  assign done      = fin;

  // R2: an idle start opens a route
  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R10: the counter begins each route at zero
  a_r10_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (hop_count == '0));

  // R5: a hop is followed by another hop or by the end of the route
  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    hop_valid |=> (hop_valid || done));

  // R6: done and hop never share a cycle
  a_r6_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && hop_valid));

endmodule

// File: tb/test_se_route_seq.sv
module test_se_route_seq;

  localparam int K        = 3;
  localparam int CLK_P    = 10;
  localparam int MAXH     = 2 * K - 1;
  localparam int CW       = $clog2(2 * K);
  localparam int WD_LIMIT = 20000;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [K-1:0]   src_addr;
  logic [K-1:0]   dst_addr;
  logic           busy;
  logic           hop_valid;
  logic           hop_type;
  logic [K-1:0]   next_addr;
  logic           done;
  logic [CW-1:0]  hop_count;

  int n_checks = 0;
  int n_fails  = 0;

  se_route_seq #(.ADDR_BITS(K)) i_se_route_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .busy      (busy),
    .hop_valid (hop_valid),
    .hop_type  (hop_type),
    .next_addr (next_addr),
    .done      (done),
    .hop_count (hop_count)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected hop list built from the routing rule in R5.
  task automatic model(input logic [K-1:0] s, input logic [K-1:0] d,
                       output int n, output int typ[MAXH], output int adr[MAXH]);
    logic [K-1:0] c;
    int  j;
    bit  rot_due;
    c = s; j = 0; rot_due = 0; n = 0;
    for (int g = 0; g < MAXH; g++) begin typ[g] = 0; adr[g] = 0; end
    while (c != d && n < MAXH) begin
      if (rot_due || c[0] == d[K-1-j]) begin
        c = {c[K-2:0], c[K-1]};
        typ[n] = 0; j++; rot_due = 0;
      end else begin
        c = c ^ K'(1);
        typ[n] = 1; rot_due = 1;
      end
      adr[n] = int'(c);
      n++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; src_addr = '0; dst_addr = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && hop_valid == 0 && done == 0, "R1 flags in reset", int'(busy), 0);
    chk(hop_count == 0, "R1 count in reset", int'(hop_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && hop_valid == 0 && done == 0, "R1 flags after release", int'(busy), 0);
    chk(hop_count == 0, "R1 count after release", int'(hop_count), 0);
  endtask

  task automatic run_route(input logic [K-1:0] s, input logic [K-1:0] d,
                           input bit poke_mid, input bit poke_end);
    int n, idx, cyc;
    int typ[MAXH];
    int adr[MAXH];
    int last_addr;
    model(s, d, n, typ, adr);
    @(negedge clk);
    start = 1'b1; src_addr = s; dst_addr = d;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1, "R2 busy after start", int'(busy), 1);
    if (s == d) chk(done == 1 && hop_valid == 0, "R7 done at once", int'(done), 1);
    idx = 0; cyc = 0; last_addr = int'(s);
    while (!done && cyc < MAXH + 2) begin
      chk(hop_valid == 1, "R5 hop each busy cycle", int'(hop_valid), 1);
      if (idx < n) begin
        chk(int'(hop_type) == typ[idx], "R5 move kind", int'(hop_type), typ[idx]);
        if (typ[idx] == 0)
          chk(int'(next_addr) == adr[idx], "R3 shuffle address", int'(next_addr), adr[idx]);
        else
          chk(int'(next_addr) == adr[idx], "R4 exchange address", int'(next_addr), adr[idx]);
      end
      last_addr = int'(next_addr);
      if (poke_mid && idx == 0) begin
        start = 1'b1; src_addr = ~s; dst_addr = ~d;
      end
      idx++; cyc++;
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1 && hop_valid == 0, "R6 done alone", int'(done), 1);
    chk(idx == n, "R8 hop total", idx, n);
    chk(idx <= MAXH, "R8 hop bound", idx, MAXH);
    chk(last_addr == int'(d), "R8 final address", last_addr, int'(d));
    chk(int'(hop_count) == n, "R10 count at done", int'(hop_count), n);
    if (poke_end) begin
      start = 1'b1; src_addr = ~s; dst_addr = ~d;
    end
    @(negedge clk);
    start = 1'b0;
    if (poke_end)
      chk(busy == 0, "R9 start in done cycle ignored", int'(busy), 0);
    chk(busy == 0 && done == 0, "R6 busy and done fall", int'(busy), 0);
    chk(int'(hop_count) == n, "R10 count held", int'(hop_count), n);
  endtask

  task automatic t_directed();
    run_route(3'd0, 3'd7, 0, 0);
    run_route(3'd6, 3'd1, 0, 0);
    run_route(3'd4, 3'd3, 0, 0);
  endtask

  task automatic t_same_node();
    run_route(3'd5, 3'd5, 0, 0);   // R7
    run_route(3'd0, 3'd0, 0, 0);   // R7
  endtask

  task automatic t_start_ignored();
    run_route(3'd2, 3'd5, 1, 0);   // R9 mid-route pulse
    run_route(3'd1, 3'd6, 0, 1);   // R9 pulse in done cycle
  endtask

  task automatic t_all_pairs();
    for (int s = 0; s < (1 << K); s++)
      for (int d = 0; d < (1 << K); d++)
        run_route(K'(s), K'(d), 0, 0);   // R8 exhaustive
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    int cnt;
    cnt = 0;
    while (cnt < WD_LIMIT) begin
      @(posedge clk);
      cnt++;
    end
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cnt, WD_LIMIT);
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_directed();
    t_same_node();
    t_start_ignored();
    t_all_pairs();
    summary();
    $finish;
  end

endmodule